// File: doc/BRIEF.md
# SECDED Memory ECC Engine

This block protects a 64-bit memory data path with a single-error-correcting, double-error-detecting Hamming code. On the write side, the incoming 64-bit word first goes through a byte-enabled merge with the word that was read earlier. The merged word is then encoded into a 72-bit codeword: the 64 data bits plus 8 check bits. On the read side, a 72-bit codeword from memory is checked. A single flipped bit is repaired and flagged. Two flipped bits are flagged as uncorrectable. The write pipeline is 1 or 2 cycles deep and the read pipeline is 1 or 3 cycles deep, each chosen by a parameter.

Two independent saturating tallies count corrected events and uncorrectable events. Each tally runs a two-state machine, TALLY_QUIET and TALLY_ALERT. The machine moves from QUIET to ALERT on an event that brings the count to or above its threshold. It stays in ALERT through further events. It returns to QUIET only when its clear input is pulsed, and that pulse also zeroes the count. The interrupt output is high exactly while the machine is in ALERT.

A fault-injection unit lets a test corrupt chosen bits of one codeword. It has two states, INJ_OFF and INJ_ARMED. A pulse on the arm input captures a 72-bit mask and moves the unit to ARMED; arming again while ARMED recaptures the mask. The next accepted write has its codeword XORed with the captured mask, and the unit then drops back to OFF.

Top module: `ecc_engine`

## Requirements
- R1: The codeword holds the data on bits 63:0 and the check bits on bits 71:64. Data bit k sits at Hamming position p(k), which is the (k+1)-th integer of 3 or more that is not a power of two. Check bit j (j = 0..6) is the XOR of the data bits whose position has bit j set. Bit 71 makes the XOR of all 72 bits zero.
- R2: A read codeword with exactly one flipped bit, in any of the 72 places, returns the original data with the corrected flag high and the uncorrectable flag low. A flip in a check bit leaves the data unchanged.
- R3: A read codeword with exactly two flipped bits raises the uncorrectable flag with the corrected flag low. The two flags are never high together.
- R4: A clean codeword returns its data with both flags low. Both flags are low whenever the read output is not valid.
- R5: In a write, byte b of the encoded data comes from the new data when the byte-enable bit b is 1, and from the previously read word when it is 0.
- R6: After an arm pulse, the next accepted write's codeword is XORed with the captured mask. Later writes are clean until the unit is armed again.
- R7: The codeword output becomes valid WR_LAT cycles (1 or 2) after a write is presented.
- R8: The read result becomes valid RD_LAT cycles (1 or 3) after a codeword is presented.
- R9: The corrected-event count rises by one per corrected read. Its interrupt rises on the event that brings the count to or above its threshold, and stays high until cleared.
- R10: The uncorrectable-event count and interrupt behave the same way, with their own threshold and clear, independently of the corrected-event tally.
- R11: Each count saturates at its all-ones value.
- R12: A clear pulse zeroes its count and drops its interrupt on the next cycle, even if an event arrives in the same cycle.
- R13: After reset, both counts are zero, both interrupts and both valid outputs are low, and injection is disarmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Write word presented |
| wr_data | input | 64 | New write data |
| wr_be | input | 8 | Byte enables, 1 selects the new byte |
| wr_old | input | 64 | Previously read word used for masked bytes |
| cw_valid | output | 1 | Encoded codeword valid |
| cw_out | output | 72 | Encoded codeword |
| inj_arm | input | 1 | Pulse that arms a one-shot injection |
| inj_mask | input | 72 | Bits to flip in the injected codeword |
| rd_valid | input | 1 | Read codeword presented |
| rd_cw | input | 72 | Codeword read from memory |
| rd_out_valid | output | 1 | Read result valid |
| rd_data | output | 64 | Corrected read data |
| rd_sbe | output | 1 | Single-bit error corrected |
| rd_dbe | output | 1 | Uncorrectable error detected |
| sbe_thresh | input | CNT_W | Corrected-event interrupt threshold |
| dbe_thresh | input | CNT_W | Uncorrectable-event interrupt threshold |
| sbe_clr | input | 1 | Clear corrected tally and interrupt |
| dbe_clr | input | 1 | Clear uncorrectable tally and interrupt |
| sbe_count | output | CNT_W | Corrected-event count |
| dbe_count | output | CNT_W | Uncorrectable-event count |
| sbe_irq | output | 1 | Corrected-event interrupt |
| dbe_irq | output | 1 | Uncorrectable-event interrupt |

## Verification
The bench builds the engine with WR_LAT=2, RD_LAT=3 and CNT_W=4. This puts the deeper pipelines under test, where the registered syndrome stage and the merge stage must carry valid, mask and data in step. The 4-bit tallies reach their saturation value of 15 within a few dozen reads, so the bench can cover the saturation, a threshold crossing and a clear that collides with an event.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int DATA_W  = 64;
    localparam int HAM_W   = 7;
    localparam int CHK_W   = HAM_W + 1;
    localparam int CW_W    = DATA_W + CHK_W;
    localparam int BYTES   = DATA_W / 8;
    localparam int HAM_TOP = DATA_W + HAM_W;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              sbe;
        logic              dbe;
    } rd_result_t;

    // XOR of the Hamming positions of all set data bits
    function automatic logic [HAM_W-1:0] ham_syn(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] acc;
        int k;
        acc = '0;
        k = 0;
        for (int p = 1; p <= HAM_TOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (d[k]) acc = acc ^ HAM_W'(p);
                k++;
            end
        end
        return acc;
    endfunction

    // one-hot mask over data bits for the position named by the syndrome
    function automatic logic [DATA_W-1:0] ham_flip(input logic [HAM_W-1:0] syn);
        logic [DATA_W-1:0] m;
        int k;
        m = '0;
        k = 0;
        for (int p = 1; p <= HAM_TOP; p++) begin
            if ((p & (p - 1)) != 0) begin
                m[k] = (syn == HAM_W'(p));
                k++;
            end
        end
        return m;
    endfunction

    function automatic logic [CW_W-1:0] ecc_encode(input logic [DATA_W-1:0] d);
        logic [CHK_W-1:0] c;
        c[HAM_W-1:0] = ham_syn(d);
        c[CHK_W-1]   = ^{d, c[HAM_W-1:0]};
        return {c, d};
    endfunction

    function automatic rd_result_t ecc_classify(input logic [DATA_W-1:0] d,
                                                input logic [HAM_W-1:0]  syn,
                                                input logic              ovp);
        rd_result_t r;
        r.data = d;
        r.sbe  = 1'b0;
        r.dbe  = 1'b0;
        if (ovp) begin
            if (int'(syn) <= HAM_TOP) begin
                r.sbe  = 1'b1;
                r.data = d ^ ham_flip(syn);
            end else begin
                r.dbe = 1'b1;
            end
        end else if (syn != '0) begin
            r.dbe = 1'b1;
        end
        return r;
    endfunction
endpackage

// File: rtl/ecc_wr_path.sv
module ecc_wr_path
    import ecc_pkg::*;
#(
    parameter int WR_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [BYTES-1:0]  wr_be,
    input  logic [DATA_W-1:0] wr_old,
    input  logic              inj_arm,
    input  logic [CW_W-1:0]   inj_mask,
    output logic              cw_valid,
    output logic [CW_W-1:0]   cw_out
);
    typedef enum logic {INJ_OFF, INJ_ARMED} inj_state_t;

    inj_state_t        inj_q, inj_nx;
    logic [CW_W-1:0]   mask_q;
    logic [CW_W-1:0]   apply_mask;
    logic [DATA_W-1:0] merged;

    always_ff @(posedge clk) begin
        if (rst) begin
            inj_q  <= INJ_OFF;
            mask_q <= '0;
        end else begin
            inj_q <= inj_nx;
            if (inj_arm) mask_q <= inj_mask;
        end
    end

    always_comb begin
        inj_nx = inj_q;
        unique case (inj_q)
            INJ_OFF:   if (inj_arm) inj_nx = INJ_ARMED;
            INJ_ARMED: begin
                if (inj_arm)       inj_nx = INJ_ARMED;
                else if (wr_valid) inj_nx = INJ_OFF;
            end
            default:   inj_nx = INJ_OFF;
        endcase
    end

    always_comb begin
        apply_mask = (inj_q == INJ_ARMED && wr_valid) ? mask_q : '0;
    end

    for (genvar b = 0; b < BYTES; b++) begin : g_merge
        assign merged[8*b +: 8] = wr_be[b] ? wr_data[8*b +: 8] : wr_old[8*b +: 8];
    end

    if (WR_LAT == 1) begin : g_lat1
        logic            v_q;
        logic [CW_W-1:0] cw_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q  <= 1'b0;
                cw_q <= '0;
            end else begin
                v_q <= wr_valid;
                if (wr_valid) cw_q <= ecc_encode(merged) ^ apply_mask;
            end
        end
        assign cw_valid = v_q;
        assign cw_out   = cw_q;
    end else begin : g_lat2
        logic              v1_q, v2_q;
        logic [DATA_W-1:0] d1_q;
        logic [CW_W-1:0]   m1_q, cw_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v1_q <= 1'b0;
                v2_q <= 1'b0;
                d1_q <= '0;
                m1_q <= '0;
                cw_q <= '0;
            end else begin
                v1_q <= wr_valid;
                if (wr_valid) begin
                    d1_q <= merged;
                    m1_q <= apply_mask;
                end
                v2_q <= v1_q;
                if (v1_q) cw_q <= ecc_encode(d1_q) ^ m1_q;
            end
        end
        assign cw_valid = v2_q;
        assign cw_out   = cw_q;
    end
endmodule

// File: rtl/ecc_rd_path.sv
module ecc_rd_path
    import ecc_pkg::*;
#(
    parameter int RD_LAT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_valid,
    input  logic [CW_W-1:0]   rd_cw,
    output logic              out_valid,
    output rd_result_t        result
);
    if (RD_LAT == 1) begin : g_lat1
        logic       v_q;
        rd_result_t r_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
                r_q <= '0;
            end else begin
                v_q <= rd_valid;
                r_q <= rd_valid
                     ? ecc_classify(rd_cw[DATA_W-1:0],
                                    ham_syn(rd_cw[DATA_W-1:0]) ^ rd_cw[DATA_W +: HAM_W],
                                    ^rd_cw)
                     : '0;
            end
        end
        assign out_valid = v_q;
        assign result    = r_q;
    end else begin : g_lat3
        logic              va_q, vb_q, vc_q;
        logic [CW_W-1:0]   cwa_q;
        logic [DATA_W-1:0] db_q;
        logic [HAM_W-1:0]  synb_q;
        logic              ovpb_q;
        rd_result_t        rc_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                va_q   <= 1'b0;
                vb_q   <= 1'b0;
                vc_q   <= 1'b0;
                cwa_q  <= '0;
                db_q   <= '0;
                synb_q <= '0;
                ovpb_q <= 1'b0;
                rc_q   <= '0;
            end else begin
                va_q <= rd_valid;
                if (rd_valid) cwa_q <= rd_cw;
                vb_q <= va_q;
                if (va_q) begin
                    db_q   <= cwa_q[DATA_W-1:0];
                    synb_q <= ham_syn(cwa_q[DATA_W-1:0]) ^ cwa_q[DATA_W +: HAM_W];
                    ovpb_q <= ^cwa_q;
                end
                vc_q <= vb_q;
                rc_q <= vb_q ? ecc_classify(db_q, synb_q, ovpb_q) : '0;
            end
        end
        assign out_valid = vc_q;
        assign result    = rc_q;
    end
endmodule

// File: rtl/ecc_err_tally.sv
module ecc_err_tally #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             event_in,
    input  logic             clr,
    input  logic [CNT_W-1:0] thresh,
    output logic [CNT_W-1:0] count,
    output logic             irq
);
    typedef enum logic {TALLY_QUIET, TALLY_ALERT} tally_state_t;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    tally_state_t     st_q, st_nx;
    logic [CNT_W-1:0] cnt_q, cnt_nx;

    always_comb begin
        cnt_nx = cnt_q;
        if (clr)                              cnt_nx = '0;
        else if (event_in && cnt_q != CNT_MAX) cnt_nx = cnt_q + 1'b1;
    end

    always_comb begin
        st_nx = st_q;
        unique case (st_q)
            TALLY_QUIET: begin
                if (!clr && event_in && cnt_nx >= thresh) st_nx = TALLY_ALERT;
            end
            TALLY_ALERT: begin
                if (clr) st_nx = TALLY_QUIET;
            end
            default: st_nx = TALLY_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= TALLY_QUIET;
            cnt_q <= '0;
        end else begin
            st_q  <= st_nx;
            cnt_q <= cnt_nx;
        end
    end

    always_comb begin
        irq   = (st_q == TALLY_ALERT);
        count = cnt_q;
    end
endmodule

// File: rtl/ecc_engine.sv
module ecc_engine
    import ecc_pkg::*;
#(
    parameter int WR_LAT = 1,
    parameter int RD_LAT = 1,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_valid,
    input  logic [63:0]       wr_data,
    input  logic [7:0]        wr_be,
    input  logic [63:0]       wr_old,
    output logic              cw_valid,
    output logic [71:0]       cw_out,
    input  logic              inj_arm,
    input  logic [71:0]       inj_mask,
    input  logic              rd_valid,
    input  logic [71:0]       rd_cw,
    output logic              rd_out_valid,
    output logic [63:0]       rd_data,
    output logic              rd_sbe,
    output logic              rd_dbe,
    input  logic [CNT_W-1:0]  sbe_thresh,
    input  logic [CNT_W-1:0]  dbe_thresh,
    input  logic              sbe_clr,
    input  logic              dbe_clr,
    output logic [CNT_W-1:0]  sbe_count,
    output logic [CNT_W-1:0]  dbe_count,
    output logic              sbe_irq,
    output logic              dbe_irq
);
    rd_result_t res;

    ecc_wr_path #(.WR_LAT(WR_LAT)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .wr_valid (wr_valid),
        .wr_data  (wr_data),
        .wr_be    (wr_be),
        .wr_old   (wr_old),
        .inj_arm  (inj_arm),
        .inj_mask (inj_mask),
        .cw_valid (cw_valid),
        .cw_out   (cw_out)
    );

    ecc_rd_path #(.RD_LAT(RD_LAT)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_valid  (rd_valid),
        .rd_cw     (rd_cw),
        .out_valid (rd_out_valid),
        .result    (res)
    );

    assign rd_data = res.data;
    assign rd_sbe  = res.sbe;
    assign rd_dbe  = res.dbe;

    ecc_err_tally #(.CNT_W(CNT_W)) u_sbe_tally (
        .clk      (clk),
        .rst      (rst),
        .event_in (rd_out_valid & res.sbe),
        .clr      (sbe_clr),
        .thresh   (sbe_thresh),
        .count    (sbe_count),
        .irq      (sbe_irq)
    );

    ecc_err_tally #(.CNT_W(CNT_W)) u_dbe_tally (
        .clk      (clk),
        .rst      (rst),
        .event_in (rd_out_valid & res.dbe),
        .clr      (dbe_clr),
        .thresh   (dbe_thresh),
        .count    (dbe_count),
        .irq      (dbe_irq)
    );
endmodule

// File: rtl/ecc_engine_chk.sv
module ecc_engine_chk #(
    parameter int WR_LAT = 1,
    parameter int RD_LAT = 1,
    parameter int CNT_W  = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             wr_valid,
    input logic             cw_valid,
    input logic             rd_valid,
    input logic             rd_out_valid,
    input logic             rd_sbe,
    input logic             rd_dbe,
    input logic             sbe_clr,
    input logic             dbe_clr,
    input logic [CNT_W-1:0] sbe_count,
    input logic [CNT_W-1:0] dbe_count,
    input logic             sbe_irq,
    input logic             dbe_irq
);
    // R3
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_sbe && rd_dbe));

    // R4
    flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_out_valid |-> (!rd_sbe && !rd_dbe));

    // R9
    sbe_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sbe_irq && !sbe_clr) |=> sbe_irq);

    // R10
    dbe_irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dbe_irq && !dbe_clr) |=> dbe_irq);

    // R11
    dbe_sat_chk: assert property (@(posedge clk) disable iff (rst)
        ((&dbe_count) && !dbe_clr) |=> (&dbe_count));

    // R12
    sbe_clear_chk: assert property (@(posedge clk) disable iff (rst)
        sbe_clr |=> (sbe_count == '0 && !sbe_irq));

    if (WR_LAT == 1) begin : g_wl1
        // R7
        wr_lat_chk: assert property (@(posedge clk) disable iff (rst)
            wr_valid |=> cw_valid);
    end else begin : g_wl2
        // R7
        wr_lat_chk: assert property (@(posedge clk) disable iff (rst)
            wr_valid |=> ##1 cw_valid);
    end

    if (RD_LAT == 1) begin : g_rl1
        // R8
        rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
            rd_valid |=> rd_out_valid);
    end else begin : g_rl3
        // R8
        rd_lat_chk: assert property (@(posedge clk) disable iff (rst)
            rd_valid |=> ##2 rd_out_valid);
    end
endmodule

bind ecc_engine ecc_engine_chk #(
    .WR_LAT(WR_LAT),
    .RD_LAT(RD_LAT),
    .CNT_W (CNT_W)
) u_ecc_engine_chk (
    .clk          (clk),
    .rst          (rst),
    .wr_valid     (wr_valid),
    .cw_valid     (cw_valid),
    .rd_valid     (rd_valid),
    .rd_out_valid (rd_out_valid),
    .rd_sbe       (rd_sbe),
    .rd_dbe       (rd_dbe),
    .sbe_clr      (sbe_clr),
    .dbe_clr      (dbe_clr),
    .sbe_count    (sbe_count),
    .dbe_count    (dbe_count),
    .sbe_irq      (sbe_irq),
    .dbe_irq      (dbe_irq)
);

// File: tb/test_ecc_engine.sv
module test_ecc_engine;
    localparam int CLK_PERIOD = 10;
    localparam int CW         = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_valid = 1'b0;
    logic [63:0]   wr_data = '0;
    logic [7:0]    wr_be = '0;
    logic [63:0]   wr_old = '0;
    logic          cw_valid;
    logic [71:0]   cw_out;
    logic          inj_arm = 1'b0;
    logic [71:0]   inj_mask = '0;
    logic          rd_valid = 1'b0;
    logic [71:0]   rd_cw = '0;
    logic          rd_out_valid;
    logic [63:0]   rd_data;
    logic          rd_sbe, rd_dbe;
    logic [CW-1:0] sbe_thresh = '0;
    logic [CW-1:0] dbe_thresh = '0;
    logic          sbe_clr = 1'b0;
    logic          dbe_clr = 1'b0;
    logic [CW-1:0] sbe_count, dbe_count;
    logic          sbe_irq, dbe_irq;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ecc_engine #(.WR_LAT(2), .RD_LAT(3), .CNT_W(CW)) i_ecc_engine (
        .clk(clk), .rst(rst),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_be(wr_be), .wr_old(wr_old),
        .cw_valid(cw_valid), .cw_out(cw_out),
        .inj_arm(inj_arm), .inj_mask(inj_mask),
        .rd_valid(rd_valid), .rd_cw(rd_cw),
        .rd_out_valid(rd_out_valid), .rd_data(rd_data), .rd_sbe(rd_sbe), .rd_dbe(rd_dbe),
        .sbe_thresh(sbe_thresh), .dbe_thresh(dbe_thresh),
        .sbe_clr(sbe_clr), .dbe_clr(dbe_clr),
        .sbe_count(sbe_count), .dbe_count(dbe_count),
        .sbe_irq(sbe_irq), .dbe_irq(dbe_irq)
    );

    function automatic logic [71:0] tb_enc(input logic [63:0] d);
        logic [7:0] c;
        int p;
        c = '0;
        p = 2;
        for (int k = 0; k < 64; k++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            for (int j = 0; j < 7; j++)
                if (d[k] && p[j]) c[j] = ~c[j];
        end
        c[7] = ^{d, c[6:0]};
        return {c, d};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [71:0] act,
                       input logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [63:0] d, input logic [7:0] be,
                            input logic [63:0] old, output logic [71:0] cw);
        @(negedge clk);
        wr_valid = 1'b1; wr_data = d; wr_be = be; wr_old = old;
        @(posedge clk); @(negedge clk);
        wr_valid = 1'b0;
        chk(cw_valid == 1'b0, "R7 early", 72'(cw_valid), 72'd0);
        @(posedge clk); @(negedge clk);
        chk(cw_valid == 1'b1, "R7 on time", 72'(cw_valid), 72'd1);
        cw = cw_out;
    endtask

    task automatic do_read(input logic [71:0] cw, output logic [63:0] d,
                           output logic s, output logic db);
        @(negedge clk);
        rd_valid = 1'b1; rd_cw = cw;
        @(posedge clk); @(negedge clk);
        rd_valid = 1'b0;
        chk(rd_out_valid == 1'b0, "R8 early1", 72'(rd_out_valid), 72'd0);
        @(posedge clk); @(negedge clk);
        chk(rd_out_valid == 1'b0, "R8 early2", 72'(rd_out_valid), 72'd0);
        @(posedge clk); @(negedge clk);
        chk(rd_out_valid == 1'b1, "R8 on time", 72'(rd_out_valid), 72'd1);
        d = rd_data; s = rd_sbe; db = rd_dbe;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic t_reset;
        chk(sbe_count == 0 && dbe_count == 0, "R13 counts", 72'({sbe_count, dbe_count}), 72'd0);
        chk(!sbe_irq && !dbe_irq, "R13 irqs", 72'({sbe_irq, dbe_irq}), 72'd0);
        chk(!cw_valid && !rd_out_valid, "R13 valids", 72'({cw_valid, rd_out_valid}), 72'd0);
    endtask

    task automatic t_encode;
        logic [63:0] pats [4];
        logic [71:0] cw;
        pats[0] = 64'h0;
        pats[1] = 64'hFFFF_FFFF_FFFF_FFFF;
        pats[2] = 64'h8000_0000_0000_0001;
        pats[3] = 64'h0123_4567_89AB_CDEF;
        for (int i = 0; i < 4; i++) begin
            do_write(pats[i], 8'hFF, 64'h0, cw);
            chk(cw == tb_enc(pats[i]), "R1 encode", cw, tb_enc(pats[i]));
        end
    endtask

    task automatic t_clean;
        logic [63:0] d; logic s, db;
        logic [63:0] v = 64'hDEAD_BEEF_0BAD_F00D;
        do_read(tb_enc(v), d, s, db);
        chk(d == v && !s && !db, "R4 clean read", {6'd0, s, db, d}, {8'd0, v});
    endtask

    task automatic t_single;
        int bits [8] = '{0, 5, 31, 63, 64, 66, 70, 71};
        logic [63:0] v = 64'hA5A5_5A5A_1234_FEDC;
        logic [63:0] d; logic s, db;
        for (int i = 0; i < 8; i++) begin
            logic [71:0] cw = tb_enc(v);
            cw[bits[i]] = ~cw[bits[i]];
            do_read(cw, d, s, db);
            chk(d == v && s && !db, "R2 single fix", {6'd0, s, db, d}, {8'b10, v});
        end
    endtask

    task automatic t_double;
        int pa [4] = '{0, 3, 70, 10};
        int pb [4] = '{1, 64, 71, 50};
        logic [63:0] v = 64'h0F0F_F0F0_3C3C_C3C3;
        logic [63:0] d; logic s, db;
        for (int i = 0; i < 4; i++) begin
            logic [71:0] cw = tb_enc(v);
            cw[pa[i]] = ~cw[pa[i]];
            cw[pb[i]] = ~cw[pb[i]];
            do_read(cw, d, s, db);
            chk(!s && db, "R3 double flag", 72'({s, db}), 72'b01);
        end
    endtask

    task automatic t_partial;
        logic [71:0] cw;
        logic [63:0] nw = 64'h1111_2222_3333_4444;
        logic [63:0] od = 64'hAAAA_BBBB_CCCC_DDDD;
        logic [7:0]  bes [3] = '{8'hA5, 8'h00, 8'h81};
        for (int i = 0; i < 3; i++) begin
            logic [63:0] m;
            for (int b = 0; b < 8; b++)
                m[8*b +: 8] = bes[i][b] ? nw[8*b +: 8] : od[8*b +: 8];
            do_write(nw, bes[i], od, cw);
            chk(cw == tb_enc(m), "R5 merge", cw, tb_enc(m));
        end
    endtask

    task automatic t_inject;
        logic [71:0] cw;
        logic [71:0] msk = 72'h0_0000_0000_0000_0008;
        logic [63:0] v = 64'h5555_AAAA_5555_AAAA;
        logic [63:0] d; logic s, db;
        @(negedge clk); inj_arm = 1'b1; inj_mask = msk;
        @(negedge clk); inj_arm = 1'b0; inj_mask = '0;
        do_write(v, 8'hFF, 64'h0, cw);
        chk(cw == (tb_enc(v) ^ msk), "R6 injected", cw, tb_enc(v) ^ msk);
        do_read(cw, d, s, db);
        chk(d == v && s, "R6 injected fix", {7'd0, s, d}, {8'd1, v});
        do_write(v, 8'hFF, 64'h0, cw);
        chk(cw == tb_enc(v), "R6 one shot", cw, tb_enc(v));
    endtask

    task automatic pulse_clr;
        @(negedge clk); sbe_clr = 1'b1; dbe_clr = 1'b1;
        @(negedge clk); sbe_clr = 1'b0; dbe_clr = 1'b0;
    endtask

    task automatic t_tally;
        logic [63:0] v = 64'h1357_9BDF_2468_ACE0;
        logic [71:0] one = tb_enc(v) ^ 72'd4;
        logic [71:0] two = tb_enc(v) ^ 72'h3;
        logic [63:0] d; logic s, db;
        sbe_thresh = 4'd3; dbe_thresh = 4'd2;
        pulse_clr();
        chk(sbe_count == 0 && !sbe_irq, "R12 clear", 72'({sbe_irq, sbe_count}), 72'd0);
        do_read(one, d, s, db);
        do_read(one, d, s, db);
        chk(sbe_count == 2 && !sbe_irq, "R9 below thresh", 72'({sbe_irq, sbe_count}), 72'h02);
        do_read(one, d, s, db);
        chk(sbe_count == 3 && sbe_irq, "R9 at thresh", 72'({sbe_irq, sbe_count}), 72'h13);
        chk(dbe_count == 0 && !dbe_irq, "R10 separate", 72'({dbe_irq, dbe_count}), 72'd0);
        for (int i = 0; i < 13; i++) do_read(one, d, s, db);
        chk(sbe_count == 4'hF && sbe_irq, "R11 saturate", 72'({sbe_irq, sbe_count}), 72'h1F);
        pulse_clr();
        chk(sbe_count == 0 && !sbe_irq, "R12 clear irq", 72'({sbe_irq, sbe_count}), 72'd0);
        // clear lands in the same cycle as a counted event
        @(negedge clk); rd_valid = 1'b1; rd_cw = one;
        @(negedge clk); rd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk); sbe_clr = 1'b1;
        chk(rd_out_valid && rd_sbe, "R12 race setup", 72'({rd_out_valid, rd_sbe}), 72'b11);
        @(negedge clk); sbe_clr = 1'b0;
        chk(sbe_count == 0 && !sbe_irq, "R12 clear wins", 72'({sbe_irq, sbe_count}), 72'd0);
        do_read(two, d, s, db);
        chk(dbe_count == 1 && !dbe_irq, "R10 below thresh", 72'({dbe_irq, dbe_count}), 72'h01);
        do_read(two, d, s, db);
        chk(dbe_count == 2 && dbe_irq, "R10 at thresh", 72'({dbe_irq, dbe_count}), 72'h12);
        chk(sbe_count == 0 && !sbe_irq, "R10 sbe untouched", 72'({sbe_irq, sbe_count}), 72'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_encode();
        t_clean();
        t_single();
        t_double();
        t_partial();
        t_inject();
        t_tally();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule